// File: doc/BRIEF.md
# Low-Frequency Reader Clock Generator and Sample Serializer

This block runs from one master clock (24 MHz in the target system). It produces every timing signal that a low-frequency RFID reader front end needs: a serial bit clock for the host link, a square-wave coil drive at the carrier frequency, and a conversion clock for the external ADC. A single selector input chooses between a 125 kHz and a roughly 136 kHz carrier. All three clocks come from the same divider, so each carrier cycle yields exactly one 8-bit sample.

On each rising edge of the ADC clock, the block captures the parallel ADC byte. During the next carrier cycle it shifts that byte, most significant bit first, onto a three-wire serial link with a frame strobe. The data line changes on falling edges of the serial clock, so the host samples it on rising edges. Pins for an unused high-frequency path are held at fixed low levels, and the related inputs are ignored.

Top module: `lf_reader_serializer`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, the outputs are: `ser_clk`=0, `ser_data`=0, `ser_frame`=0, `coil_drv`=1, `adc_clk`=0, `dbg_out`=0.
- R2: `ser_clk` is a square wave whose period is 2*(11+s) master cycles, with 11+s cycles high and 11+s cycles low. s is the latched selector value: `sel_125k`=1 gives 24 cycles, and 0 gives 22 cycles.
- R3: A change on `sel_125k` takes effect only at the next falling edge of `ser_clk`. No high or low phase ever has a length other than 11 or 12 master cycles.
- R4: Serial periods are numbered in slots 0 to 7, and the slot number advances on each falling edge of `ser_clk`. `coil_drv` is 1 in slots 0 to 3 and 0 in slots 4 to 7, so it changes only on a falling edge of `ser_clk`.
- R5: `adc_clk` is the complement of `coil_drv`, so it rises once per carrier cycle, on the edge where `coil_drv` falls. `dbg_out` always equals `adc_clk`.
- R6: On the master edge where `adc_clk` rises, the block latches `adc_data`. In the next slot 0 to 7 sequence, `ser_data` carries the latched byte, bit 7 in slot 0 down to bit 0 in slot 7. `ser_data` changes only on falling edges of `ser_clk`.
- R7: `ser_frame` stays 0 until the first byte has been latched. It rises together with the MSB of the first frame and then stays high, because frames follow back to back.
- R8: `hf_pwr` and all bits of `coil_oe` are always 0. The inputs `hf_clk`, `hf_clk_n`, `host_din`, `cmp_hi` and `cmp_lo` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_125k | input | 1 | Carrier select: 1 gives 125 kHz, 0 gives about 136 kHz |
| adc_data | input | 8 | Parallel ADC sample |
| hf_clk | input | 1 | Unused high-frequency clock, ignored |
| hf_clk_n | input | 1 | Unused complementary high-frequency clock, ignored |
| host_din | input | 1 | Unused host-to-block data, ignored |
| cmp_hi | input | 1 | Unused comparator input, ignored |
| cmp_lo | input | 1 | Unused comparator input, ignored |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial sample data, MSB first |
| ser_frame | output | 1 | Frame strobe |
| coil_drv | output | 1 | Coil drive square wave at the carrier frequency |
| adc_clk | output | 1 | ADC conversion clock |
| dbg_out | output | 1 | Copy of adc_clk |
| hf_pwr | output | 1 | High-frequency power drive, held low |
| coil_oe | output | 4 | Coil output enables, held low |

## Verification
The checker enforces several relations on every cycle:
- `ser_data` and `coil_drv` change only on a falling edge of `ser_clk`.
- `adc_clk` rises only where `coil_drv` falls.
- `dbg_out` mirrors `adc_clk`.
- The frame never drops.
- The fixed outputs stay low.
- Neither level of `ser_clk` lasts past its largest bound.

Some properties need the bench's reference model and scenarios:
- The exact period for each selector value.
- That a mid-period selector change waits for the period boundary.
- That the byte shifted out is the one present at the latching edge, in MSB-first order.
- That toggling the ignored inputs changes nothing.

// File: rtl/lf_rdr_pkg.sv
package lf_rdr_pkg;
   // Half-period of the serial clock in master cycles for a given selector.
   function automatic int unsigned half_len(input int unsigned base, input logic sel);
      return base + (sel ? 1 : 0);
   endfunction
endpackage

// File: rtl/lf_bitclk_div.sv
module lf_bitclk_div #(
   parameter int unsigned BASE_HALF = 11,
   localparam int unsigned HCNT_W = $clog2(BASE_HALF + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic sel,
   output logic ser_clk,
   output logic fall_evt
);
   import lf_rdr_pkg::*;

   logic [HCNT_W-1:0] hcnt_q;
   logic              sel_q;
   logic [HCNT_W-1:0] last_cnt;
   logic              tick;

   assign last_cnt = HCNT_W'(half_len(BASE_HALF, sel_q) - 1);
   assign tick     = (hcnt_q == last_cnt);
   assign fall_evt = tick && ser_clk;

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt_q  <= '0;
         ser_clk <= 1'b0;
         sel_q   <= sel;
      end else if (tick) begin
         hcnt_q  <= '0;
         ser_clk <= ~ser_clk;
         if (ser_clk) sel_q <= sel;   // selector only re-sampled at period boundary
      end else begin
         hcnt_q  <= hcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lf_slot_seq.sv
module lf_slot_seq #(
   parameter int unsigned SLOTS = 8,
   localparam int unsigned SLOT_W = $clog2(SLOTS),
   localparam int unsigned HALF_SLOTS = SLOTS / 2
) (
   input  logic clk,
   input  logic rst,
   input  logic fall_evt,
   output logic coil_drv,
   output logic adc_clk,
   output logic cap_evt,
   output logic load_evt
);
   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst)
         slot_q <= '0;
      else if (fall_evt)
         slot_q <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
   end

   assign coil_drv = (slot_q < SLOT_W'(HALF_SLOTS));
   assign adc_clk  = ~coil_drv;
   assign cap_evt  = fall_evt && (slot_q == SLOT_W'(HALF_SLOTS - 1));
   assign load_evt = fall_evt && (slot_q == SLOT_W'(SLOTS - 1));
endmodule

// File: rtl/lf_byte_shifter.sv
module lf_byte_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_evt,
   input  logic              load_evt,
   input  logic              fall_evt,
   input  logic [DATA_W-1:0] din,
   output logic              ser_data,
   output logic              ser_frame
);
   logic [DATA_W-1:0] cap_q;
   logic              cap_valid_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next  = {sh_q[DATA_W-2:0], 1'b0};
         assign ser_data = sh_q[DATA_W-1];
      end else begin : g_lsb
         assign sh_next  = {1'b0, sh_q[DATA_W-1:1]};
         assign ser_data = sh_q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_q       <= '0;
         cap_valid_q <= 1'b0;
         sh_q        <= '0;
         ser_frame   <= 1'b0;
      end else begin
         if (cap_evt) begin
            cap_q       <= din;
            cap_valid_q <= 1'b1;
         end
         if (load_evt) begin
            sh_q      <= cap_q;
            ser_frame <= cap_valid_q;
         end else if (fall_evt) begin
            sh_q      <= sh_next;
         end
      end
   end
endmodule

// File: rtl/lf_reader_serializer.sv
module lf_reader_serializer #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BASE_HALF = 11,
   parameter int unsigned OE_W      = 4,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_125k,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              hf_clk,
   input  logic              hf_clk_n,
   input  logic              host_din,
   input  logic              cmp_hi,
   input  logic              cmp_lo,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_frame,
   output logic              coil_drv,
   output logic              adc_clk,
   output logic              dbg_out,
   output logic              hf_pwr,
   output logic [OE_W-1:0]   coil_oe
);
   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_w
         $error("DATA_W must be even and at least 2");
      end
      if (BASE_HALF < 2) begin : g_bad_half
         $error("BASE_HALF must be at least 2");
      end
   endgenerate

   logic fall_evt;
   logic cap_evt;
   logic load_evt;
   logic unused_inputs;

   assign unused_inputs = ^{hf_clk, hf_clk_n, host_din, cmp_hi, cmp_lo};

   lf_bitclk_div #(.BASE_HALF(BASE_HALF)) i_div (
      .clk(clk), .rst(rst), .sel(sel_125k),
      .ser_clk(ser_clk), .fall_evt(fall_evt)
   );

   lf_slot_seq #(.SLOTS(DATA_W)) i_seq (
      .clk(clk), .rst(rst), .fall_evt(fall_evt),
      .coil_drv(coil_drv), .adc_clk(adc_clk),
      .cap_evt(cap_evt), .load_evt(load_evt)
   );

   lf_byte_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) i_shf (
      .clk(clk), .rst(rst), .cap_evt(cap_evt), .load_evt(load_evt),
      .fall_evt(fall_evt), .din(adc_data),
      .ser_data(ser_data), .ser_frame(ser_frame)
   );

   assign dbg_out = adc_clk;
   assign hf_pwr  = 1'b0;
   assign coil_oe = '0;
endmodule

// File: rtl/lf_reader_checker.sv
module lf_reader_checker #(
   parameter int unsigned OE_W      = 4,
   parameter int unsigned BASE_HALF = 11
) (
   input logic            clk,
   input logic            rst,
   input logic            ser_clk,
   input logic            ser_data,
   input logic            ser_frame,
   input logic            coil_drv,
   input logic            adc_clk,
   input logic            dbg_out,
   input logic            hf_pwr,
   input logic [OE_W-1:0] coil_oe
);
   logic       prev_q;
   logic [7:0] run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         run_q  <= '0;
      end else begin
         prev_q <= ser_clk;
         run_q  <= (ser_clk != prev_q) ? '0 : run_q + 1'b1;
      end
   end

   AST_SER_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
      run_q <= 8'(BASE_HALF + 1)); // R2
   AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (rst)
      !$stable(ser_data) |-> $fell(ser_clk)); // R6
   AST_COIL_AT_FALL: assert property (@(posedge clk) disable iff (rst)
      !$stable(coil_drv) |-> $fell(ser_clk)); // R4
   AST_ADC_WITH_COIL: assert property (@(posedge clk) disable iff (rst)
      $rose(adc_clk) |-> $fell(coil_drv)); // R5
   AST_DBG_MIRROR: assert property (@(posedge clk) disable iff (rst)
      dbg_out == adc_clk); // R5
   AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (rst)
      ser_frame |=> ser_frame); // R7
   AST_FIXED_LOW: assert property (@(posedge clk) disable iff (rst)
      !hf_pwr && (coil_oe == '0)); // R8
endmodule

bind lf_reader_serializer lf_reader_checker #(.OE_W(OE_W), .BASE_HALF(BASE_HALF)) i_chk (
   .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
   .ser_frame(ser_frame), .coil_drv(coil_drv), .adc_clk(adc_clk),
   .dbg_out(dbg_out), .hf_pwr(hf_pwr), .coil_oe(coil_oe)
);

// File: tb/test_lf_reader_serializer.sv
module test_lf_reader_serializer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sel_125k = 1'b1;
   logic [7:0] adc_data = 8'h00;
   logic       hf_clk = 0, hf_clk_n = 0, host_din = 0, cmp_hi = 0, cmp_lo = 0;
   logic       ser_clk, ser_data, ser_frame, coil_drv, adc_clk, dbg_out, hf_pwr;
   logic [3:0] coil_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lf_reader_serializer i_lf_reader_serializer (
      .clk(clk), .rst(rst), .sel_125k(sel_125k), .adc_data(adc_data),
      .hf_clk(hf_clk), .hf_clk_n(hf_clk_n), .host_din(host_din),
      .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_frame(ser_frame),
      .coil_drv(coil_drv), .adc_clk(adc_clk), .dbg_out(dbg_out),
      .hf_pwr(hf_pwr), .coil_oe(coil_oe)
   );

   // Behavioural reference: phase within serial period, slot, latched byte.
   int m_t, m_slot, m_selq, m_cap, m_valid, m_sh, m_frame, m_half;
   always @(posedge clk) begin
      if (rst) begin
         m_t = 0; m_slot = 0; m_selq = sel_125k; m_cap = 0;
         m_valid = 0; m_sh = 0; m_frame = 0;
      end else begin
         m_half = 11 + m_selq;
         if (m_t == 2 * m_half - 1) begin
            m_t = 0;
            m_selq = sel_125k;
            if (m_slot == 3) begin m_cap = adc_data; m_valid = 1; end
            m_slot = (m_slot + 1) % 8;
            if (m_slot == 0) begin m_sh = m_cap; m_frame = m_valid; end
            else m_sh = (m_sh << 1) & 255;
         end else begin
            m_t = m_t + 1;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison and period measurement, sampled on the falling edge.
   int  cyc_since_fall = 0;
   int  exp_period = 0;
   bit  prev_ser = 0;
   bit  have_fall = 0;
   always @(negedge clk) begin
      if (rst) begin
         have_fall = 0; prev_ser = 0; cyc_since_fall = 0;
      end else if (!done) begin
         chk("R2", "ser_clk", ser_clk, (m_t >= 11 + m_selq) ? 1 : 0);
         chk("R4", "coil_drv", coil_drv, (m_slot < 4) ? 1 : 0);
         chk("R5", "adc_clk", adc_clk, (m_slot >= 4) ? 1 : 0);
         chk("R5", "dbg_out", dbg_out, adc_clk);
         chk("R6", "ser_data", ser_data, (m_sh >> 7) & 1);
         chk("R7", "ser_frame", ser_frame, m_frame);
         chk("R8", "hf_pwr/coil_oe", {hf_pwr, coil_oe}, 0);
         cyc_since_fall++;
         if (prev_ser && !ser_clk) begin
            if (have_fall) chk("R3", "serial period", cyc_since_fall, exp_period);
            exp_period = 2 * (11 + m_selq);
            have_fall = 1;
            cyc_since_fall = 0;
         end
         prev_ser = ser_clk;
      end
   end

   task automatic hold(input int cycles, input bit noisy);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (noisy) begin
            hf_clk = ~hf_clk; hf_clk_n = ~hf_clk; host_din = k[2];
            cmp_hi = k[1]; cmp_lo = k[3];
         end
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "ser_clk rst", ser_clk, 0);
      chk("R1", "ser_data rst", ser_data, 0);
      chk("R1", "ser_frame rst", ser_frame, 0);
      chk("R1", "coil_drv rst", coil_drv, 1);
      chk("R1", "adc_clk rst", adc_clk, 0);
      chk("R1", "dbg_out rst", dbg_out, 0);
      rst = 1'b0;
      // R6 R7: distinct bytes at 125 kHz, quiet ignored inputs
      adc_data = 8'hA5; hold(400, 0);
      adc_data = 8'h3C; hold(400, 0);
      // R8: ignored inputs toggling
      adc_data = 8'hFF; hold(400, 1);
      adc_data = 8'h00; hold(400, 1);
      // R3: selector change in mid-period, then 136 kHz bytes
      hold(7, 0);
      sel_125k = 1'b0;
      adc_data = 8'h81; hold(400, 0);
      adc_data = 8'h5A; hold(400, 1);
      // back to 125 kHz mid-period, byte changing every cycle
      hold(13, 0);
      sel_125k = 1'b1;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         adc_data = 8'(k * 37 + 11);
      end
      // reset again mid-stream: R1
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      chk("R1", "ser_frame re-rst", ser_frame, 0);
      chk("R1", "coil_drv re-rst", coil_drv, 1);
      rst = 1'b0;
      hold(300, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule